// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block holds the control step that carries a processor core from normal execution into a handler. The core presents a pending exception code, a hardware interrupt request with its level and vector code, and its live state: status word, program counter, general register 15, vector base and the two delay-slot flags. When the core raises `take_event` and something is eligible, the block decides which event wins. It acknowledges in the same cycle. On that clock edge it commits the saved copies of the status word, PC and stack register, the event code, the new status word and the handler address, all together.

The block also covers the case where the status word already blocks events. A blocked exception becomes a reset entry and a blocked interrupt is left pending. A fault on an instruction in a branch delay slot saves a PC that re-executes the branch. A trap instruction saves the address of the instruction after it. Where the handler starts depends on the class of the event.

Top module: `exc_entry_seq`

## Requirements
- R1: A pending exception (`exc_valid`) always wins over a pending interrupt. When an exception is taken, `intevt_o` keeps its old value.
- R2: If status bit 28 (block) of `cur_sr` is set, an exception with any code other than 0x1E0 is entered as code 0x000, the reset class. Code 0x1E0 keeps its code and goes to `vbr`+0x100. An interrupt gets no `ack` and leaves every output register unchanged.
- R3: On every entry `ssr_o` takes `cur_sr` and `sgr_o` takes `cur_r15`. The new `sr_o` is `cur_sr` with bits 28, 29 (register bank) and 30 (privileged) set.
- R4: `spc_o` takes `cur_pc`, or `cur_pc`-2 when either bit of `dslot_flags` is set. `dslot_clr` is high exactly when `ack` is high.
- R5: An exception writes its effective code to `expevt_o`. An interrupt writes `irq_code` to `intevt_o`, leaves `expevt_o` unchanged and jumps to `vbr`+0x600.
- R6: The reset-class codes 0x000, 0x020 and 0x140 clear status bit 15 (FPU disable), set status bits 7:4 (interrupt mask) to 0xF and jump to 0xA0000000.
- R7: Codes 0x040 and 0x060 jump to `vbr`+0x400. Every other exception code jumps to `vbr`+0x100. Code 0x160 (trap) adds 2 to the saved PC, on top of any delay-slot step.
- R8: An interrupt is accepted only when `irq_level` is strictly greater than `cur_sr[7:4]`. Otherwise it gets no `ack` and changes nothing.
- R9: `ack` is combinational and is high in the cycle in which `take_event` is high and an event is eligible. Without `ack`, every output register holds its value.
- R10: With synchronous `rst` high, the outputs go to: `sr_o`=0x700000F0, `pc_o`=0xA0000000, `expevt_o`=0, and `ssr_o`, `spc_o`, `sgr_o`, `intevt_o` all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| take_event | input | 1 | Core permits entry this cycle |
| exc_valid | input | 1 | An exception is pending |
| exc_code | input | 12 | Code of the pending exception |
| irq_req | input | 1 | Hardware interrupt request |
| irq_level | input | 4 | Priority level of the request |
| irq_code | input | 12 | Vector code of the request |
| cur_sr | input | 32 | Current status word |
| cur_pc | input | 32 | PC of the faulting or next instruction |
| cur_r15 | input | 32 | Current general register 15 |
| vbr | input | 32 | Vector base address |
| dslot_flags | input | 2 | Delay-slot flags (unconditional, conditional) |
| ack | output | 1 | Entry accepted this cycle |
| dslot_clr | output | 1 | Clear the delay-slot flags |
| sr_o | output | 32 | New status word |
| pc_o | output | 32 | Handler address |
| ssr_o | output | 32 | Saved status word |
| spc_o | output | 32 | Saved PC |
| sgr_o | output | 32 | Saved register 15 |
| expevt_o | output | 12 | Exception event code |
| intevt_o | output | 12 | Interrupt event code |

## Verification
The hardest situations to reach are the blocked-state corners. These are an exception arriving while bit 28 is set, where 0x1E0 alone keeps its identity, and an interrupt whose level equals the mask exactly. Both are needed to tell a correct compare from an off-by-one compare. Directed steps place each of these cases with interrupt and exception requested together or alone. The random phase sets the block bit in about a quarter of the steps, draws codes mostly from the special list (including 0x1E0 and the trap code with delay-slot flags), and derives interrupt levels near the current mask.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int CODE_W   = 12;
  localparam int SR_MD    = 30;
  localparam int SR_RB    = 29;
  localparam int SR_BL    = 28;
  localparam int SR_FD    = 15;
  localparam int SR_IM_LO = 4;
  localparam int SR_IM_W  = 4;

  localparam logic [CODE_W-1:0] C_POWERON  = 12'h000;
  localparam logic [CODE_W-1:0] C_MANUAL   = 12'h020;
  localparam logic [CODE_W-1:0] C_TLBMISSR = 12'h040;
  localparam logic [CODE_W-1:0] C_TLBMISSW = 12'h060;
  localparam logic [CODE_W-1:0] C_TLBMULTI = 12'h140;
  localparam logic [CODE_W-1:0] C_TRAP     = 12'h160;
  localparam logic [CODE_W-1:0] C_BLOCK_OK = 12'h1E0;

  typedef enum logic [2:0] {
    EVC_NONE,
    EVC_RESET,
    EVC_TLBMISS,
    EVC_GENERAL,
    EVC_TRAP,
    EVC_IRQ
  } evclass_t;

  function automatic evclass_t classify_exc(input logic [CODE_W-1:0] c);
    evclass_t r;
    case (c)
      C_POWERON, C_MANUAL, C_TLBMULTI: r = EVC_RESET;
      C_TLBMISSR, C_TLBMISSW:          r = EVC_TLBMISS;
      C_TRAP:                          r = EVC_TRAP;
      default:                         r = EVC_GENERAL;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/exc_entry_arb.sv
module exc_entry_arb
  import exc_entry_pkg::*;
#(
  parameter int LVL_W = SR_IM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_req,
  input  logic [LVL_W-1:0]  irq_level,
  input  logic              sr_bl,
  input  logic [LVL_W-1:0]  sr_imask,
  output logic              fire,
  output logic              sel_irq,
  output logic [CODE_W-1:0] eff_code,
  output evclass_t          cls
);
  logic irq_ok;
  logic masked_exc;

  assign irq_ok     = irq_req && !sr_bl && (irq_level > sr_imask);
  assign masked_exc = exc_valid && sr_bl && (exc_code != C_BLOCK_OK);
  assign eff_code   = masked_exc ? C_POWERON : exc_code;
  assign fire       = exc_valid || irq_ok;
  assign sel_irq    = !exc_valid && irq_ok;

  always_comb begin
    if (!fire)        cls = EVC_NONE;
    else if (sel_irq) cls = EVC_IRQ;
    else              cls = classify_exc(eff_code);
  end

  // R1
  exc_wins_chk: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> (fire && !sel_irq && cls != EVC_IRQ));

  // R8
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    (cls == EVC_IRQ) |-> (irq_level > sr_imask));

  // R2
  blocked_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (exc_valid && sr_bl && exc_code != C_BLOCK_OK) |-> (cls == EVC_RESET && eff_code == '0));

  // R2
  blocked_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (sr_bl && !exc_valid) |-> !fire);
endmodule

// File: rtl/exc_entry_tgt.sv
module exc_entry_tgt
  import exc_entry_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter logic [31:0] RESET_PC = 32'hA000_0000,
  parameter logic [31:0] OFS_GEN  = 32'h0000_0100,
  parameter logic [31:0] OFS_TLB  = 32'h0000_0400,
  parameter logic [31:0] OFS_IRQ  = 32'h0000_0600
) (
  input  evclass_t        cls,
  input  logic [XLEN-1:0] cur_sr,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] vbr,
  input  logic            in_dslot,
  output logic [XLEN-1:0] tgt_pc,
  output logic [XLEN-1:0] save_pc,
  output logic [XLEN-1:0] next_sr
);
  localparam logic [XLEN-1:0] STEP = XLEN'(2);

  function automatic logic [XLEN-1:0] calc_target(input evclass_t c, input logic [XLEN-1:0] base);
    logic [XLEN-1:0] r;
    case (c)
      EVC_RESET:   r = XLEN'(RESET_PC);
      EVC_TLBMISS: r = base + XLEN'(OFS_TLB);
      EVC_IRQ:     r = base + XLEN'(OFS_IRQ);
      default:     r = base + XLEN'(OFS_GEN);
    endcase
    return r;
  endfunction

  function automatic logic [XLEN-1:0] calc_saved(input evclass_t c, input logic [XLEN-1:0] pc,
                                                 input logic ds);
    logic [XLEN-1:0] r;
    r = ds ? (pc - STEP) : pc;
    if (c == EVC_TRAP) r = r + STEP;
    return r;
  endfunction

  function automatic logic [XLEN-1:0] calc_sr(input evclass_t c, input logic [XLEN-1:0] s);
    logic [XLEN-1:0] r;
    r = s;
    r[SR_BL] = 1'b1;
    r[SR_MD] = 1'b1;
    r[SR_RB] = 1'b1;
    if (c == EVC_RESET) begin
      r[SR_FD] = 1'b0;
      r[SR_IM_LO +: SR_IM_W] = '1;
    end
    return r;
  endfunction

  assign tgt_pc  = calc_target(cls, vbr);
  assign save_pc = calc_saved(cls, cur_pc, in_dslot);
  assign next_sr = calc_sr(cls, cur_sr);
endmodule

// File: rtl/exc_entry_regs.sv
module exc_entry_regs
  import exc_entry_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter logic [31:0] RESET_PC = 32'hA000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              sel_irq,
  input  logic [CODE_W-1:0] eff_code,
  input  logic [CODE_W-1:0] irq_code,
  input  logic [XLEN-1:0]   next_sr,
  input  logic [XLEN-1:0]   tgt_pc,
  input  logic [XLEN-1:0]   save_pc,
  input  logic [XLEN-1:0]   cur_sr,
  input  logic [XLEN-1:0]   cur_r15,
  output logic [XLEN-1:0]   sr_o,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   ssr_o,
  output logic [XLEN-1:0]   spc_o,
  output logic [XLEN-1:0]   sgr_o,
  output logic [CODE_W-1:0] expevt_o,
  output logic [CODE_W-1:0] intevt_o
);
  function automatic logic [XLEN-1:0] reset_sr();
    logic [XLEN-1:0] r;
    r = '0;
    r[SR_BL] = 1'b1;
    r[SR_MD] = 1'b1;
    r[SR_RB] = 1'b1;
    r[SR_IM_LO +: SR_IM_W] = '1;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_o     <= reset_sr();
      pc_o     <= XLEN'(RESET_PC);
      ssr_o    <= '0;
      spc_o    <= '0;
      sgr_o    <= '0;
      expevt_o <= C_POWERON;
      intevt_o <= '0;
    end else if (load) begin
      sr_o  <= next_sr;
      pc_o  <= tgt_pc;
      ssr_o <= cur_sr;
      spc_o <= save_pc;
      sgr_o <= cur_r15;
      if (sel_irq) intevt_o <= irq_code;
      else         expevt_o <= eff_code;
    end
  end

  // R3
  entry_bits_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (sr_o[SR_BL] && sr_o[SR_MD] && sr_o[SR_RB]));

  // R3
  save_state_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (ssr_o == $past(cur_sr) && sgr_o == $past(cur_r15)));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(pc_o) && $stable(sr_o) && $stable(spc_o) && $stable(expevt_o) && $stable(intevt_o)));

  // R1
  exc_keeps_intevt_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !sel_irq) |=> $stable(intevt_o));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          LVL_W    = SR_IM_W,
  parameter int          DS_W     = 2,
  parameter logic [31:0] RESET_PC = 32'hA000_0000,
  parameter logic [31:0] OFS_GEN  = 32'h0000_0100,
  parameter logic [31:0] OFS_TLB  = 32'h0000_0400,
  parameter logic [31:0] OFS_IRQ  = 32'h0000_0600
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_event,
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_req,
  input  logic [LVL_W-1:0]  irq_level,
  input  logic [CODE_W-1:0] irq_code,
  input  logic [XLEN-1:0]   cur_sr,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   cur_r15,
  input  logic [XLEN-1:0]   vbr,
  input  logic [DS_W-1:0]   dslot_flags,
  output logic              ack,
  output logic              dslot_clr,
  output logic [XLEN-1:0]   sr_o,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   ssr_o,
  output logic [XLEN-1:0]   spc_o,
  output logic [XLEN-1:0]   sgr_o,
  output logic [CODE_W-1:0] expevt_o,
  output logic [CODE_W-1:0] intevt_o
);
  logic              fire;
  logic              sel_irq;
  logic [CODE_W-1:0] eff_code;
  evclass_t          cls;
  logic [XLEN-1:0]   tgt_pc;
  logic [XLEN-1:0]   save_pc;
  logic [XLEN-1:0]   next_sr;
  logic              in_dslot;

  assign in_dslot  = |dslot_flags;
  assign ack       = take_event && fire;
  assign dslot_clr = ack;

  exc_entry_arb #(.LVL_W(LVL_W)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .exc_valid (exc_valid),
    .exc_code  (exc_code),
    .irq_req   (irq_req),
    .irq_level (irq_level),
    .sr_bl     (cur_sr[SR_BL]),
    .sr_imask  (cur_sr[SR_IM_LO +: LVL_W]),
    .fire      (fire),
    .sel_irq   (sel_irq),
    .eff_code  (eff_code),
    .cls       (cls)
  );

  exc_entry_tgt #(
    .XLEN(XLEN), .RESET_PC(RESET_PC),
    .OFS_GEN(OFS_GEN), .OFS_TLB(OFS_TLB), .OFS_IRQ(OFS_IRQ)
  ) u_tgt (
    .cls      (cls),
    .cur_sr   (cur_sr),
    .cur_pc   (cur_pc),
    .vbr      (vbr),
    .in_dslot (in_dslot),
    .tgt_pc   (tgt_pc),
    .save_pc  (save_pc),
    .next_sr  (next_sr)
  );

  exc_entry_regs #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .load     (ack),
    .sel_irq  (sel_irq),
    .eff_code (eff_code),
    .irq_code (irq_code),
    .next_sr  (next_sr),
    .tgt_pc   (tgt_pc),
    .save_pc  (save_pc),
    .cur_sr   (cur_sr),
    .cur_r15  (cur_r15),
    .sr_o     (sr_o),
    .pc_o     (pc_o),
    .ssr_o    (ssr_o),
    .spc_o    (spc_o),
    .sgr_o    (sgr_o),
    .expevt_o (expevt_o),
    .intevt_o (intevt_o)
  );

  // R6
  reset_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && cls == EVC_RESET) |=> (pc_o == XLEN'(RESET_PC) && sr_o[SR_IM_LO +: SR_IM_W] == '1 && !sr_o[SR_FD]));

  // R5
  irq_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && sel_irq) |=> (pc_o == $past(vbr) + XLEN'(OFS_IRQ) && intevt_o == $past(irq_code) && $stable(expevt_o)));

  // R4
  dslot_clr_chk: assert property (@(posedge clk) disable iff (rst)
    dslot_clr |-> take_event);
endmodule

// File: tb/exc_entry_seq_test.sv
module exc_entry_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        take_event = 1'b0;
  logic        exc_valid = 1'b0;
  logic [11:0] exc_code = '0;
  logic        irq_req = 1'b0;
  logic [3:0]  irq_level = '0;
  logic [11:0] irq_code = '0;
  logic [31:0] cur_sr = '0, cur_pc = '0, cur_r15 = '0, vbr = '0;
  logic [1:0]  dslot_flags = '0;
  logic        ack, dslot_clr;
  logic [31:0] sr_o, pc_o, ssr_o, spc_o, sgr_o;
  logic [11:0] expevt_o, intevt_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] m_sr, m_pc, m_ssr, m_spc, m_sgr;
  logic [11:0] m_exp, m_int;

  always #10 clk = ~clk;

  exc_entry_seq uut (
    .clk(clk), .rst(rst), .take_event(take_event), .exc_valid(exc_valid),
    .exc_code(exc_code), .irq_req(irq_req), .irq_level(irq_level),
    .irq_code(irq_code), .cur_sr(cur_sr), .cur_pc(cur_pc), .cur_r15(cur_r15),
    .vbr(vbr), .dslot_flags(dslot_flags), .ack(ack), .dslot_clr(dslot_clr),
    .sr_o(sr_o), .pc_o(pc_o), .ssr_o(ssr_o), .spc_o(spc_o), .sgr_o(sgr_o),
    .expevt_o(expevt_o), .intevt_o(intevt_o)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_sr = 32'h7000_00F0; m_pc = 32'hA000_0000;
    m_ssr = 0; m_spc = 0; m_sgr = 0; m_exp = 0; m_int = 0;
  endtask

  task automatic check_all(input string tag);
    chk(tag, "sr", sr_o, m_sr);
    chk(tag, "pc", pc_o, m_pc);
    chk(tag, "ssr", ssr_o, m_ssr);
    chk(tag, "spc", spc_o, m_spc);
    chk(tag, "sgr", sgr_o, m_sgr);
    chk(tag, "expevt", {20'h0, expevt_o}, {20'h0, m_exp});
    chk(tag, "intevt", {20'h0, intevt_o}, {20'h0, m_int});
  endtask

  // bench-side restatement of entry rules
  function automatic bit is_reset_code(input logic [11:0] c);
    return (c == 12'h000) || (c == 12'h020) || (c == 12'h140);
  endfunction

  function automatic logic [31:0] entry_offset(input logic [11:0] c);
    if (c == 12'h040 || c == 12'h060) return 32'h400;
    return 32'h100;
  endfunction

  task automatic step(input string tag, input bit tk, input bit ev, input logic [11:0] ec,
                      input bit ir, input logic [3:0] il, input logic [11:0] ic,
                      input logic [31:0] sr, input logic [31:0] pc, input logic [31:0] r15,
                      input logic [31:0] vb, input logic [1:0] ds);
    bit take_exc, take_irq, exp_ack;
    logic [11:0] code;
    logic [31:0] ns, sp;
    @(negedge clk);
    take_event = tk; exc_valid = ev; exc_code = ec; irq_req = ir; irq_level = il;
    irq_code = ic; cur_sr = sr; cur_pc = pc; cur_r15 = r15; vbr = vb; dslot_flags = ds;
    take_exc = ev;
    take_irq = !ev && ir && !sr[28] && (il > sr[7:4]);
    code = (sr[28] && ec != 12'h1E0) ? 12'h000 : ec;
    exp_ack = tk && (take_exc || take_irq);
    #1;
    chk(tag, "ack", {31'h0, ack}, {31'h0, exp_ack});
    chk("R4", "dslot_clr", {31'h0, dslot_clr}, {31'h0, exp_ack});
    if (exp_ack) begin
      m_ssr = sr; m_sgr = r15;
      ns = sr | 32'h7000_0000;
      sp = (ds != 2'b00) ? pc - 32'd2 : pc;
      if (take_irq) begin
        m_int = ic;
        m_pc = vb + 32'h600;
      end else begin
        m_exp = code;
        if (is_reset_code(code)) begin
          ns = (ns & ~32'h0000_8000) | 32'h0000_00F0;
          m_pc = 32'hA000_0000;
        end else begin
          m_pc = vb + entry_offset(code);
        end
        if (code == 12'h160) sp = sp + 32'd2;
      end
      m_sr = ns; m_spc = sp;
    end
    @(posedge clk);
    #1 take_event = 1'b0;
    @(negedge clk);
    check_all(tag);
  endtask

  function automatic logic [11:0] pick_code(input int unsigned n);
    case (n % 16)
      0: return 12'h000;  1: return 12'h020;  2: return 12'h040;  3: return 12'h060;
      4: return 12'h080;  5: return 12'h0A0;  6: return 12'h0C0;  7: return 12'h0E0;
      8: return 12'h100;  9: return 12'h140;  10: return 12'h160; 11: return 12'h180;
      12: return 12'h1A0; 13: return 12'h1E0; 14: return 12'h1E0;
      default: return 12'($urandom);
    endcase
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check_all("R10");

    // R1: exception and interrupt together; exception wins, intevt kept
    step("R1", 1, 1, 12'h0A0, 1, 4'hF, 12'h320, 32'h0000_0000, 32'h1000, 32'h2222, 32'h8000_0000, 2'b00);
    // R5: interrupt alone, level above mask
    step("R5", 1, 0, 12'h000, 1, 4'h4, 12'h340, 32'h0000_0030, 32'h1100, 32'h3333, 32'h8000_0000, 2'b00);
    // R8: level equal to mask is refused
    step("R8", 1, 0, 12'h000, 1, 4'h5, 12'h360, 32'h0000_0050, 32'h1200, 32'h4444, 32'h8000_0000, 2'b00);
    // R8: level one above mask is accepted
    step("R8", 1, 0, 12'h000, 1, 4'h6, 12'h380, 32'h0000_0050, 32'h1204, 32'h4444, 32'h9000_0000, 2'b00);
    // R2: blocked exception becomes reset entry
    step("R2", 1, 1, 12'h0A0, 0, 4'h0, 12'h000, 32'h1000_8030, 32'h1300, 32'h5555, 32'h8000_0000, 2'b00);
    // R2: blocked 0x1E0 keeps its code
    step("R2", 1, 1, 12'h1E0, 0, 4'h0, 12'h000, 32'h1000_0000, 32'h1400, 32'h6666, 32'h8100_0000, 2'b00);
    // R2: blocked interrupt ignored
    step("R2", 1, 0, 12'h000, 1, 4'hF, 12'h3A0, 32'h1000_0000, 32'h1500, 32'h7777, 32'h8200_0000, 2'b00);
    // R6: manual reset code clears FD, sets mask
    step("R6", 1, 1, 12'h020, 0, 4'h0, 12'h000, 32'h0000_8030, 32'h1600, 32'h8888, 32'h8300_0000, 2'b00);
    // R7: TLB miss offset
    step("R7", 1, 1, 12'h040, 0, 4'h0, 12'h000, 32'h0000_0000, 32'h1700, 32'h9999, 32'h8400_0000, 2'b00);
    // R7: trap in delay slot, both adjustments
    step("R7", 1, 1, 12'h160, 0, 4'h0, 12'h000, 32'h0000_0000, 32'h1800, 32'hAAAA, 32'h8500_0000, 2'b10);
    // R4: general exception in delay slot
    step("R4", 1, 1, 12'h0E0, 0, 4'h0, 12'h000, 32'h0000_0000, 32'h1900, 32'hBBBB, 32'h8600_0000, 2'b01);
    // R9: no take_event, nothing changes
    step("R9", 0, 1, 12'h040, 1, 4'hF, 12'h3C0, 32'h0000_0000, 32'h1A00, 32'hCCCC, 32'h8700_0000, 2'b00);
    // R3: status bits and saved registers on plain entry
    step("R3", 1, 1, 12'h180, 0, 4'h0, 12'h000, 32'h0000_1234, 32'h1B00, 32'hDDDD, 32'h8800_0000, 2'b00);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] sr;
      logic [3:0] lv;
      sr = $urandom;
      sr[28] = (($urandom % 4) == 0);
      lv = sr[7:4] + 4'(($urandom % 3)) - 4'd1;
      step("R3", (($urandom % 8) != 0), (($urandom % 2) == 0), pick_code($urandom),
           (($urandom % 2) == 0), lv, 12'($urandom), sr, $urandom & 32'hFFFF_FFFE,
           $urandom, $urandom & 32'hFFFF_F000, 2'($urandom));
    end

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    check_all("R10");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule